// File: doc/BRIEF.md
# Dual BCD Minutes-Seconds Countdown Timer

This block holds two independent countdown timers of the kind found on a kitchen appliance. Each one stores its time as four binary-coded decimal digits, minutes and seconds, so every digit can be handed straight to a display decoder with no binary-to-decimal conversion. An operator sets a timer by stepping its minutes or its seconds up one at a time. The operator can also clear the timer or start it.

Once started, a timer loses one second on every pulse of a shared one-hertz tick enable. It borrows across digits as needed. When it reaches zero it stops and raises its done flag. The two timers share one 4-bit digit output. A timer-select input picks which timer is shown, and a 2-bit digit select picks which of that timer's four digits is shown, so a scanned display can fetch the digits one at a time.

Top module: `dual_mmss_timer`

## Requirements
- R1: After reset every timer reads 00:00, is stopped, and has done low.
- R2: Seconds tens stay in 0..5, and minutes tens and the units digits stay in their BCD ranges. The digit select encoding is 0 = seconds units, 1 = seconds tens, 2 = minutes units, 3 = minutes tens, and timer_sel gives the index of the timer that is shown.
- R3: A seconds increment adds one second. Seconds 59 wraps to 00 and does not carry into the minutes.
- R4: A minutes increment adds one minute. Minutes 59 wraps to 00, and the seconds are left alone.
- R5: Clear has the highest priority. It sets the time to 00:00, stops the timer and drops done, even when an increment, go or tick arrives in the same cycle.
- R6: Go starts a timer whose time is not zero. Go on a timer at 00:00 has no effect: the timer stays stopped and done stays low.
- R7: A running timer loses exactly one second on each tick, borrowing from x:00 to (x-1):59. A stopped timer ignores ticks.
- R8: A tick that brings a running timer to 00:00 stops it and raises done. Done then holds and further ticks change nothing, until a clear or an increment.
- R9: In any cycle with an increment, the increment takes effect and a tick in the same cycle is dropped. The increment clears done, and a running timer keeps running.
- R10: Each timer responds only to its own increment, clear and go inputs. Activity on one timer never changes the other.
- R11: A running timer that sits at 00:00 (after its digits wrap) raises done and stops on the next tick, with no decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second, shared by both timers |
| inc_min | input | 2 | Per-timer minutes increment step |
| inc_sec | input | 2 | Per-timer seconds increment step |
| clr | input | 2 | Per-timer clear |
| go | input | 2 | Per-timer start |
| timer_sel | input | 1 | Timer whose digits are shown |
| digit_sel | input | 2 | Digit shown (0 s units, 1 s tens, 2 m units, 3 m tens) |
| digit | output | 4 | Selected BCD digit |
| done | output | 2 | Per-timer countdown finished flag |

## Verification
The hardest state to reach is a timer that is running while it reads 00:00. A tick can never produce it, because the tick that reaches zero also stops the timer. The bench sets a timer to 59:59, starts it, and then steps the minutes and the seconds in the same cycle so both wrap together. It then checks that the next tick gives done with no borrow.

A long run counts a second timer down from 59:59 to zero. Meanwhile the first timer receives an interleaved schedule of increments, starts and clears, with ticks landing on the same cycles as those controls. This exercises the priority order and the independence of the two timers.

// File: rtl/ktimer_pkg.sv
package ktimer_pkg;
    localparam int unsigned DIGIT_W   = 4;
    localparam int unsigned TENS_W    = 3;
    localparam int unsigned UNITS_MAX = 9;
    localparam int unsigned TENS_MAX  = 5;

    typedef struct packed {
        logic [TENS_W-1:0]  min_t;
        logic [DIGIT_W-1:0] min_u;
        logic [TENS_W-1:0]  sec_t;
        logic [DIGIT_W-1:0] sec_u;
    } mmss_t;

    typedef struct packed {
        mmss_t t;
        logic  run;
        logic  done;
    } tmr_state_t;

    function automatic int unsigned mmss_to_secs(mmss_t v);
        int unsigned mins;
        int unsigned secs;
        mins = int'(v.min_t) * 10 + int'(v.min_u);
        secs = int'(v.sec_t) * 10 + int'(v.sec_u);
        return mins * 60 + secs;
    endfunction
endpackage

// File: rtl/mmss_countdown.sv
module mmss_countdown
    import ktimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  inc_min,
    input  logic  inc_sec,
    input  logic  clr,
    input  logic  go,
    output mmss_t time_o,
    output logic  done_o
);
    tmr_state_t st_q, st_d;
    mmss_t      dec_d;
    logic       zero_q;
    logic       any_inc;

    assign zero_q  = (st_q.t == '0);
    assign any_inc = inc_min | inc_sec;

    // borrow chain: seconds units -> seconds tens -> minutes units -> minutes tens
    always_comb begin
        dec_d = st_q.t;
        if (st_q.t.sec_u != '0) begin
            dec_d.sec_u = st_q.t.sec_u - 1'b1;
        end else begin
            dec_d.sec_u = DIGIT_W'(UNITS_MAX);
            if (st_q.t.sec_t != '0) begin
                dec_d.sec_t = st_q.t.sec_t - 1'b1;
            end else begin
                dec_d.sec_t = TENS_W'(TENS_MAX);
                if (st_q.t.min_u != '0) begin
                    dec_d.min_u = st_q.t.min_u - 1'b1;
                end else begin
                    dec_d.min_u = DIGIT_W'(UNITS_MAX);
                    dec_d.min_t = st_q.t.min_t - 1'b1;
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (any_inc) begin
            if (inc_sec) begin
                if (st_q.t.sec_u == DIGIT_W'(UNITS_MAX)) begin
                    st_d.t.sec_u = '0;
                    st_d.t.sec_t = (st_q.t.sec_t == TENS_W'(TENS_MAX)) ? '0 : st_q.t.sec_t + 1'b1;
                end else begin
                    st_d.t.sec_u = st_q.t.sec_u + 1'b1;
                end
            end
            if (inc_min) begin
                if (st_q.t.min_u == DIGIT_W'(UNITS_MAX)) begin
                    st_d.t.min_u = '0;
                    st_d.t.min_t = (st_q.t.min_t == TENS_W'(TENS_MAX)) ? '0 : st_q.t.min_t + 1'b1;
                end else begin
                    st_d.t.min_u = st_q.t.min_u + 1'b1;
                end
            end
            st_d.done = 1'b0;
        end else if (st_q.run && tick) begin
            if (zero_q) begin
                st_d.run  = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.t = dec_d;
                if (dec_d == '0) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end else if (go && !zero_q) begin
            st_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q.t;
    assign done_o = st_q.done;

    p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.t.sec_u <= DIGIT_W'(UNITS_MAX) && st_q.t.sec_t <= TENS_W'(TENS_MAX) &&
        st_q.t.min_u <= DIGIT_W'(UNITS_MAX) && st_q.t.min_t <= TENS_W'(TENS_MAX));

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.t == '0 && !st_q.run && !st_q.done));

    p_tick_one_sec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_inc && st_q.run && tick && !zero_q) |=>
        (mmss_to_secs(st_q.t) + 1 == mmss_to_secs($past(st_q.t))));

    p_stopped_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_inc && !st_q.run) |=> $stable(st_q.t));

    p_done_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.run);

    p_inc_drops_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && any_inc) |=> !st_q.done);

    p_zero_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_inc && st_q.run && tick && zero_q) |=> (st_q.done && $stable(st_q.t)));
endmodule

// File: rtl/digit_select_mux.sv
module digit_select_mux
    import ktimer_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2,
    parameter int unsigned SEL_W    = 1
) (
    input  mmss_t [N_TIMERS-1:0] times_i,
    input  logic  [SEL_W-1:0]    timer_sel,
    input  logic  [1:0]          digit_sel,
    output logic  [DIGIT_W-1:0]  digit_o
);
    mmss_t picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < int'(N_TIMERS); i++) begin
            if (timer_sel == SEL_W'(i)) picked = times_i[i];
        end
    end

    always_comb begin
        unique case (digit_sel)
            2'd0: digit_o = picked.sec_u;
            2'd1: digit_o = DIGIT_W'(picked.sec_t);
            2'd2: digit_o = picked.min_u;
            default: digit_o = DIGIT_W'(picked.min_t);
        endcase
    end
endmodule

// File: rtl/dual_mmss_timer.sv
module dual_mmss_timer
    import ktimer_pkg::*;
#(
    parameter int unsigned N_TIMERS = 2,
    parameter int unsigned SEL_W    = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [N_TIMERS-1:0] inc_min,
    input  logic [N_TIMERS-1:0] inc_sec,
    input  logic [N_TIMERS-1:0] clr,
    input  logic [N_TIMERS-1:0] go,
    input  logic [SEL_W-1:0]    timer_sel,
    input  logic [1:0]          digit_sel,
    output logic [3:0]          digit,
    output logic [N_TIMERS-1:0] done
);
    mmss_t [N_TIMERS-1:0] times;

    for (genvar g = 0; g < int'(N_TIMERS); g++) begin : g_timer
        mmss_countdown u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (sec_tick),
            .inc_min (inc_min[g]),
            .inc_sec (inc_sec[g]),
            .clr     (clr[g]),
            .go      (go[g]),
            .time_o  (times[g]),
            .done_o  (done[g])
        );
    end

    digit_select_mux #(.N_TIMERS(N_TIMERS), .SEL_W(SEL_W)) u_mux (
        .times_i   (times),
        .timer_sel (timer_sel),
        .digit_sel (digit_sel),
        .digit_o   (digit)
    );

    p_digit_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        digit <= 4'd9);
endmodule

// File: tb/dual_mmss_timer_tb.sv
`timescale 1ns/100ps
module dual_mmss_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [1:0] inc_min = '0, inc_sec = '0, clr = '0, go = '0;
    logic       timer_sel = 1'b0;
    logic [1:0] digit_sel = '0;
    logic [3:0] digit;
    logic [1:0] done;

    int vectors = 0;
    int errors  = 0;
    int m_m[2], m_s[2];
    bit m_run[2], m_done[2];

    always #10 clk = ~clk;

    dual_mmss_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .inc_min(inc_min), .inc_sec(inc_sec), .clr(clr), .go(go),
        .timer_sel(timer_sel), .digit_sel(digit_sel),
        .digit(digit), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // R2 digit order: 0 s units, 1 s tens, 2 m units, 3 m tens
    task automatic check_all(input string tag);
        for (int t = 0; t < 2; t++) begin
            timer_sel = t[0];
            for (int d = 0; d < 4; d++) begin
                int exp;
                digit_sel = d[1:0];
                #1;
                exp = (d == 0) ? m_s[t] % 10 : (d == 1) ? m_s[t] / 10 :
                      (d == 2) ? m_m[t] % 10 : m_m[t] / 10;
                check($sformatf("%s R2 timer%0d digit%0d", tag, t, d), int'(digit), exp);
            end
            check($sformatf("%s done timer%0d", tag, t), int'(done[t]), int'(m_done[t]));
        end
    endtask

    task automatic model(input logic [1:0] im, input logic [1:0] is,
                         input logic [1:0] cl, input logic [1:0] g, input logic tk);
        for (int t = 0; t < 2; t++) begin
            int tot;
            tot = m_m[t] * 60 + m_s[t];
            if (cl[t]) begin
                m_m[t] = 0; m_s[t] = 0; m_run[t] = 0; m_done[t] = 0;
            end else if (im[t] || is[t]) begin
                if (is[t]) m_s[t] = (m_s[t] + 1) % 60;
                if (im[t]) m_m[t] = (m_m[t] + 1) % 60;
                m_done[t] = 0;
            end else if (m_run[t] && tk) begin
                if (tot == 0) begin
                    m_run[t] = 0; m_done[t] = 1;
                end else begin
                    tot--;
                    m_m[t] = tot / 60; m_s[t] = tot % 60;
                    if (tot == 0) begin m_run[t] = 0; m_done[t] = 1; end
                end
            end else if (g[t] && tot != 0) begin
                m_run[t] = 1;
            end
        end
    endtask

    task automatic step(input logic [1:0] im, input logic [1:0] is, input logic [1:0] cl,
                        input logic [1:0] g, input logic tk, input string tag);
        inc_min = im; inc_sec = is; clr = cl; go = g; sec_tick = tk;
        @(posedge clk);
        model(im, is, cl, g, tk);
        @(negedge clk);
        inc_min = '0; inc_sec = '0; clr = '0; go = '0; sec_tick = 1'b0;
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        for (int t = 0; t < 2; t++) begin
            m_m[t] = 0; m_s[t] = 0; m_run[t] = 0; m_done[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R3: seconds sweep with wrap, minutes untouched
        for (int i = 0; i < 60; i++) step(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, "R3 sec step");
        // R4: minutes sweep with wrap on timer 1
        for (int i = 0; i < 60; i++) step(2'b10, 2'b00, 2'b00, 2'b00, 1'b0, "R4 min step");

        // R6: go at 00:00 does nothing
        step(2'b00, 2'b00, 2'b00, 2'b01, 1'b0, "R6 go at zero");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R6 tick after zero go");
        step(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, "R6 load 00:01");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R7 stopped ignores tick");

        // R7/R8: 02:03 countdown on timer 0, timer 1 idle (R10)
        step(2'b00, 2'b00, 2'b01, 2'b00, 1'b0, "R5 clear");
        for (int i = 0; i < 2; i++) step(2'b01, 2'b01, 2'b00, 2'b00, 1'b0, "R4 load");
        step(2'b00, 2'b01, 2'b00, 2'b00, 1'b0, "R3 load");
        step(2'b00, 2'b00, 2'b00, 2'b01, 1'b0, "R6 go");
        for (int i = 0; i < 123; i++) step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R7 R10 countdown");
        for (int i = 0; i < 3; i++) step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R8 hold at zero");
        step(2'b00, 2'b01, 2'b00, 2'b00, 1'b1, "R9 inc clears done");

        // R11: running timer wrapped to 00:00
        step(2'b00, 2'b00, 2'b10, 2'b00, 1'b0, "R5 clear t1");
        for (int i = 0; i < 59; i++) step(2'b10, 2'b10, 2'b00, 2'b00, 1'b0, "R3 R4 load 59:59");
        step(2'b00, 2'b00, 2'b00, 2'b10, 1'b0, "R6 go t1");
        step(2'b10, 2'b10, 2'b00, 2'b00, 1'b1, "R9 wrap while running");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R11 tick at zero");
        step(2'b00, 2'b00, 2'b00, 2'b00, 1'b1, "R8 stays done");

        // R5: clear beats increment, go and tick
        step(2'b11, 2'b11, 2'b11, 2'b11, 1'b1, "R5 clear priority");

        // long sweep: timer 1 from 59:59 down, timer 0 under mixed controls
        for (int i = 0; i < 59; i++) step(2'b10, 2'b10, 2'b00, 2'b00, 1'b0, "R4 reload");
        step(2'b00, 2'b00, 2'b00, 2'b10, 1'b0, "R6 go full");
        for (int i = 0; i < 4600; i++) begin
            logic [1:0] im, is, cl, g;
            im = {1'b0, (i % 97) == 5};
            is = {1'b0, (i % 41) == 0};
            cl = {1'b0, (i % 503) == 250};
            g  = {1'b0, (i % 37) == 3};
            step(im, is, cl, g, (i % 5) != 4, "R7 R9 R10 sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule